// File: doc/BRIEF.md
# Packet Buffer Slot Allocator

This block manages a fixed pool of packet buffer slots and hands out slot numbers when asked. A controller issues commands on a single strobed command port. An allocate command claims the lowest-numbered free slot. A release command returns a slot number to the pool. A reset-pool command frees every slot. The outcome of each allocation goes into an 8-bit result byte. Its top bit is a failure flag and its low bits hold the granted slot number. A completion flag is raised whenever an allocation finishes.

An allocation that finds the pool full is not dropped. The request stays pending and the failure flag stays set. As soon as a slot is released, the pending request takes that slot without further action from the controller. It then clears the failure flag and raises the completion flag. The completion flag and the result byte change on the same clock edge. Software can therefore issue a command, poll the flag, and then read the byte, which is already valid.

Top module: `pkt_alloc_unit`

## Requirements
- R1: After hardware reset, `alloc_result` reads 0x80 (failure bit 7 set, all other bits 0) and `alloc_int` is 0.
- R2: An allocate command (opcode 01) accepted with at least one free slot updates `alloc_result` on the next clock edge. Bit 7 becomes 0, bits 6:5 become 0, and bits 4:0 hold the granted slot number. On the same edge `alloc_int` becomes 1.
- R3: The slot granted is always the lowest-numbered free slot. A granted slot is never granted again until it has been released.
- R4: An allocate command that finds no free slot sets bit 7 of `alloc_result` on the next edge, leaves bits 6:0 unchanged, and does not set `alloc_int`.
- R5: While a request is pending, bit 7 stays 1. A release command (opcode 10) frees slot `cmd_pnum` on its edge. The pending request is granted on the following edge with the freed number, bit 7 cleared, and `alloc_int` set.
- R6: An allocate command issued while a request is pending is ignored.
- R7: A reset-pool command (opcode 11) frees every slot, cancels any pending request, and sets `alloc_result` to 0x80 on the next edge. `alloc_int` is left as it was.
- R8: `alloc_int` stays 1 until an `int_ack` pulse clears it. If an allocation completes in the same cycle as an acknowledge, the flag is set.
- R9: Releasing a slot that is already free changes neither the pool nor the outputs.
- R10: Opcode 00 and any cycle with `cmd_valid` low have no effect on the pool, the pending request or `alloc_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 00 none, 01 allocate, 10 release, 11 reset pool |
| cmd_pnum | input | 5 | Slot number for a release command |
| int_ack | input | 1 | Clears the completion flag |
| alloc_result | output | 8 | Result byte: bit 7 failure, bits 4:0 slot number |
| alloc_int | output | 1 | Allocation-complete flag |

## Verification
The assertions assume that the slot number on a release command is within the pool. They also assume that a release names a slot the controller actually holds, or else one that is already free. They do not assume a clean command order: allocates may arrive while a request is pending, and acknowledges may coincide with completions. The random stimulus draws release numbers only from the pool range. It weights the opcodes so that the pool repeatedly fills, fails, drains and gets reset. A cycle-accurate bench model predicts both outputs on every cycle.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_ALLOC   = 2'b01,
    OP_RELEASE = 2'b10,
    OP_RESET   = 2'b11
  } alloc_op_e;

  localparam int RESULT_W = 8;
  localparam int FAIL_BIT = RESULT_W - 1;
  localparam logic [RESULT_W-1:0] RESULT_RST = 8'h80;
endpackage

// File: rtl/slot_bitmap.sv
module slot_bitmap #(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_en,
  input  logic             release_en,
  input  logic [IDX_W-1:0] release_idx,
  input  logic             reset_en,
  output logic             any_free,
  output logic [IDX_W-1:0] low_idx
);
  logic [SLOTS-1:0] free_q;

  function automatic logic [IDX_W-1:0] first_set(input logic [SLOTS-1:0] v);
    first_set = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (v[i]) first_set = IDX_W'(i);
  endfunction

  assign any_free = |free_q;
  assign low_idx  = first_set(free_q);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic rel_hit, grant_hit;
    assign rel_hit   = release_en && (release_idx == IDX_W'(g));
    assign grant_hit = grant_en && (low_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          free_q[g] <= 1'b1;
      else if (reset_en)   free_q[g] <= 1'b1;
      else if (grant_hit)  free_q[g] <= 1'b0;
      else if (rel_hit)    free_q[g] <= 1'b1;
    end
  end

  // R3: a grant only ever takes a slot that is currently free
  a_r3_grant_from_free: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |-> free_q[low_idx]);
  // R3: the granted slot is marked taken after the edge
  a_r3_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_en && !reset_en) |=> !free_q[$past(low_idx)]);
  // R7: reset-pool leaves every slot free
  a_r7_all_free: assert property (@(posedge clk) disable iff (!rst_n)
    reset_en |=> (&free_q));
endmodule

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import pkt_alloc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_cmd,
  input  logic                reset_cmd,
  input  logic                int_ack,
  input  logic                any_free,
  input  logic [IDX_W-1:0]    low_idx,
  output logic                grant_fire,
  output logic [RESULT_W-1:0] result,
  output logic                alloc_int
);
  logic pending_q, alloc_int_q;
  logic [RESULT_W-1:0] result_q;
  logic alloc_take, fail_fire;

  function automatic logic [RESULT_W-1:0] pack_ok(input logic [IDX_W-1:0] idx);
    pack_ok = RESULT_W'(idx);
  endfunction

  assign alloc_take = alloc_cmd && !pending_q;
  assign grant_fire = (alloc_take || pending_q) && any_free && !reset_cmd;
  assign fail_fire  = alloc_take && !any_free && !reset_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      result_q  <= RESULT_RST;
    end else if (reset_cmd) begin
      pending_q <= 1'b0;
      result_q  <= RESULT_RST;
    end else if (grant_fire) begin
      pending_q <= 1'b0;
      result_q  <= pack_ok(low_idx);
    end else if (fail_fire) begin
      pending_q <= 1'b1;
      result_q[FAIL_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alloc_int_q <= 1'b0;
    else if (grant_fire) alloc_int_q <= 1'b1;
    else if (int_ack)    alloc_int_q <= 1'b0;
  end

  assign result    = result_q;
  assign alloc_int = alloc_int_q;

  // R5: failure bit is held for as long as a request waits
  a_r5_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> result_q[FAIL_BIT]);
  // R2: a completed grant reports success and raises the flag
  a_r2_grant_done: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (alloc_int_q && !result_q[FAIL_BIT]));
  // R8: flag is sticky until acknowledged
  a_r8_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_int_q && !int_ack) |=> alloc_int_q);
  // R6: with a request waiting and nothing free, the result does not move
  a_r6_pending_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !any_free && !reset_cmd) |=> $stable(result_q));
  // R4: a failing allocate does not raise the flag
  a_r4_no_int_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_fire && !alloc_int_q) |=> !alloc_int_q);
endmodule

// File: rtl/pkt_alloc_unit.sv
module pkt_alloc_unit
  import pkt_alloc_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_pnum,
  input  logic             int_ack,
  output logic [7:0]       alloc_result,
  output logic             alloc_int
);
  logic alloc_cmd, release_cmd, reset_cmd;
  logic any_free, grant_fire;
  logic [IDX_W-1:0] low_idx;
  alloc_op_e op;

  assign op          = alloc_op_e'(cmd_op);
  assign alloc_cmd   = cmd_valid && (op == OP_ALLOC);
  assign release_cmd = cmd_valid && (op == OP_RELEASE);
  assign reset_cmd   = cmd_valid && (op == OP_RESET);

  slot_bitmap #(.SLOTS(SLOTS)) u_bitmap (
    .clk(clk), .rst_n(rst_n),
    .grant_en(grant_fire),
    .release_en(release_cmd), .release_idx(cmd_pnum),
    .reset_en(reset_cmd),
    .any_free(any_free), .low_idx(low_idx)
  );

  alloc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_cmd(alloc_cmd), .reset_cmd(reset_cmd), .int_ack(int_ack),
    .any_free(any_free), .low_idx(low_idx),
    .grant_fire(grant_fire), .result(alloc_result), .alloc_int(alloc_int)
  );

  // R7: reset-pool puts the result byte back to its reset value
  a_r7_result_rst: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (alloc_result == RESULT_RST));
  // R10: an idle cycle with nothing pending leaves the result unchanged
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !grant_fire) |=> $stable(alloc_result));
endmodule

// File: tb/sim_pkt_alloc_unit.sv
module sim_pkt_alloc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, int_ack = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [4:0] cmd_pnum = '0;
  logic [7:0] alloc_result;
  logic alloc_int;

  int checks = 0, fails = 0;

  logic [SLOTS-1:0] m_free;
  logic m_pend, m_int;
  logic [7:0] m_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_alloc_unit u0 (.*);

  function automatic int lowest(input logic [SLOTS-1:0] f);
    for (int i = 0; i < SLOTS; i++) if (f[i]) return i;
    return -1;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, compare at the next negedge
  task automatic step(input logic v, input logic [1:0] op, input logic [4:0] pn,
                      input logic ack, input string tag);
    int lo;
    logic rst_c, alloc_c, rel_c, g;
    logic [SLOTS-1:0] nf;
    logic np, ni;
    logic [7:0] nr;
    cmd_valid = v; cmd_op = op; cmd_pnum = pn; int_ack = ack;
    lo = lowest(m_free);
    rst_c   = v && op == 2'b11;
    alloc_c = v && op == 2'b01 && !m_pend;
    rel_c   = v && op == 2'b10;
    g = (alloc_c || m_pend) && (lo >= 0) && !rst_c;
    nf = m_free; np = m_pend; nr = m_res; ni = m_int;
    if (rst_c) begin nf = '1; np = 1'b0; nr = 8'h80; end
    else begin
      if (rel_c) nf[pn] = 1'b1;
      if (g) begin nf[lo] = 1'b0; np = 1'b0; nr = 8'(lo); end
      else if (alloc_c && lo < 0) begin np = 1'b1; nr[7] = 1'b1; end
    end
    if (g) ni = 1'b1; else if (ack) ni = 1'b0;
    @(negedge clk);
    m_free = nf; m_pend = np; m_res = nr; m_int = ni;
    check(alloc_result == m_res, tag, alloc_result, m_res);
    check(alloc_int == m_int, tag, alloc_int, m_int);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_free = '1; m_pend = 0; m_int = 0; m_res = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(alloc_result == 8'h80, "R1", alloc_result, 8'h80);
    check(alloc_int == 1'b0, "R1", alloc_int, 0);

    // R2/R3: fill the pool in ascending order
    for (int i = 0; i < SLOTS; i++) begin
      step(1, 2'b01, 0, 0, "R2");
      check(alloc_result == 8'(i), "R3", alloc_result, i);
    end
    step(0, 2'b00, 0, 1, "R8");
    check(alloc_int == 0, "R8", alloc_int, 0);
    // R4: full pool
    step(1, 2'b01, 0, 0, "R4");
    check(alloc_result == 8'h9F && !alloc_int, "R4", alloc_result, 8'h9F);
    // R6: allocate while pending
    step(1, 2'b01, 0, 0, "R6");
    check(alloc_result == 8'h9F, "R6", alloc_result, 8'h9F);
    // R5: release then grant one edge later
    step(1, 2'b10, 5'd7, 0, "R5");
    check(alloc_result[7] == 1'b1 && !alloc_int, "R5", alloc_result, 8'h9F);
    step(0, 2'b00, 0, 0, "R5");
    check(alloc_result == 8'h07 && alloc_int, "R5", alloc_result, 8'h07);
    // R8: ack coinciding with completion
    step(0, 2'b00, 0, 1, "R8");
    step(1, 2'b01, 0, 0, "R4");
    step(1, 2'b10, 5'd3, 0, "R5");
    step(0, 2'b00, 0, 1, "R8");
    check(alloc_int == 1 && alloc_result == 8'h03, "R8", alloc_result, 8'h03);
    step(0, 2'b00, 0, 0, "R8");
    check(alloc_int == 1, "R8", alloc_int, 1);
    // R9: release a slot that is free
    step(1, 2'b10, 5'd20, 0, "R9");
    step(1, 2'b10, 5'd20, 0, "R9");
    check(alloc_result == 8'h03, "R9", alloc_result, 8'h03);
    step(1, 2'b01, 0, 1, "R9");
    check(alloc_result == 8'd20, "R9", alloc_result, 20);
    // R10: strobe low and no-op opcode
    step(0, 2'b11, 0, 0, "R10");
    step(1, 2'b00, 5'd2, 0, "R10");
    check(alloc_result == 8'd20, "R10", alloc_result, 20);
    // R7: pool reset cancels a pending request
    step(1, 2'b01, 0, 0, "R4");
    step(1, 2'b11, 0, 0, "R7");
    check(alloc_result == 8'h80 && alloc_int, "R7", alloc_result, 8'h80);
    step(1, 2'b10, 5'd1, 0, "R7");
    step(0, 2'b00, 0, 0, "R7");
    check(alloc_result == 8'h80, "R7", alloc_result, 8'h80);
    step(1, 2'b01, 0, 0, "R7");
    check(alloc_result == 8'h00, "R7", alloc_result, 0);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] op;
      r = int'($urandom_range(0, 99));
      op = (r < 55) ? 2'b01 : (r < 93) ? 2'b10 : (r < 95) ? 2'b11 : 2'b00;
      step(($urandom_range(0, 9) != 0), op, 5'($urandom_range(0, SLOTS-1)),
           ($urandom_range(0, 3) == 0), "R3");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule